// File: doc/BRIEF.md
# Per-Channel Overcurrent Chopping Controller

This block decides, for each of a set of low-side output channels, whether the channel's power switch may conduct. Each channel takes a requested on/off level and the raw flag of an overcurrent comparator. It produces a gate enable and a flag that says the channel is in chopping mode. A channel that is requested on conducts continuously until its comparator reports excess current. The controller then forces the switch off for a long cool-down interval. After that it lets the switch conduct for a short probe window. If the excess current is still present at the end of the probe window, the off/probe cycle starts again, which gives a low duty cycle into a shorted load. If the excess current has gone, the channel returns to continuous conduction.

Every channel has its own qualifier and state machine and shares nothing with the others. A load whose current later climbs into the limit moves from continuous conduction back into chopping. A request that drops ends any phase at once. The comparator flag passes through a two-stage synchroniser and must then stay high for a set number of consecutive clocks before it counts as a fault. The window lengths are counted in clock cycles. The defaults give 40 µs on and 2.5 ms off at 50 MHz.

Each channel's state machine has four states:

| State | Gate | Chopping |
|-------|------|----------|
| CH_IDLE | off | low |
| CH_CONDUCT | on | low |
| CH_OFFWAIT | off | high |
| CH_ONWIN | on | high |

Its transitions are:

| Transition | Condition |
|------------|-----------|
| CH_IDLE → CH_CONDUCT | request high |
| CH_CONDUCT → CH_OFFWAIT | qualified fault |
| CH_OFFWAIT → CH_ONWIN | last cool-down cycle |
| CH_ONWIN → CH_OFFWAIT | last probe cycle, fault present |
| CH_ONWIN → CH_CONDUCT | last probe cycle, no fault |
| any state → CH_IDLE | request low |

Top module: `chop_guard`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, every channel goes idle, and after that edge all `gate_en` and `chopping` bits are 0.
- R2: A channel whose request bit is 0 has `gate_en` 0 and `chopping` 0 from the next clock edge on, whatever its overcurrent input does.
- R3: A channel that is idle and whose request bit is 1 at a clock edge drives `gate_en` 1 after that edge, with `chopping` 0.
- R4: The overcurrent input counts as a fault only once it has been sampled high on QUAL consecutive edges after the two-stage synchroniser. A pulse that lasts QUAL-1 cycles has no effect. A pulse that lasts QUAL cycles trips the channel QUAL+3 edges after the pulse is first sampled.
- R5: A qualified fault during continuous conduction turns the gate off and sets `chopping`. The gate then stays off for exactly OFF_CYC cycles.
- R6: After the off interval, the gate is on for exactly ON_CYC cycles, with `chopping` still 1.
- R7: If the fault is still qualified on the last cycle of the on window, the channel returns to the off interval. The gate goes to 0 and `chopping` stays 1.
- R8: If the fault is not qualified on the last cycle of the on window, the channel conducts continuously with `chopping` 0. A later fault sends it back into chopping.
- R9: A request that falls during the off interval or the on window returns the channel to idle on the next edge. When the request returns, the channel starts again in continuous conduction.
- R10: Channels are independent. A fault or request change on one channel never alters the outputs of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NCH | Requested on state per channel |
| oc_raw | input | NCH | Asynchronous overcurrent comparator flag per channel |
| gate_en | output | NCH | Gate enable per channel, 1 means conduct |
| chopping | output | NCH | 1 while the channel is in its off interval or on window |

## Verification
The hardest case to reach is the end of the probe window. The decision there depends on a qualified fault that is sampled exactly on the last window cycle, and that fault has travelled through the synchroniser and the consecutive-cycle counter. The bench shortens both windows and the qualification length. It holds the comparator high through several whole cycles to see the channel return to the off interval. It then drops the comparator part-way through an off interval, so that the counter has emptied before the next window ends and the channel returns to continuous conduction. A cycle-by-cycle arithmetic model of every channel runs alongside these scenarios. It also covers sweeps of pulse lengths around the qualification threshold on each channel.

// File: rtl/chop_pkg.sv
package chop_pkg;
    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_CONDUCT = 2'd1,
        CH_OFFWAIT = 2'd2,
        CH_ONWIN   = 2'd3
    } chan_state_t;
endpackage

// File: rtl/oc_qual.sv
module oc_qual #(
    parameter int QUAL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_raw,
    output logic fault
);
    localparam int CW = $clog2(QUAL + 1);

    logic          sync1;
    logic          sync2;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1   <= 1'b0;
            sync2   <= 1'b0;
            run_cnt <= '0;
        end else begin
            sync1 <= oc_raw;
            sync2 <= sync1;
            if (!sync2)
                run_cnt <= '0;
            else if (run_cnt != CW'(QUAL))
                run_cnt <= run_cnt + 1'b1;
        end
    end

    assign fault = (run_cnt == CW'(QUAL));

    // R4: a fault can only appear after the synchronised flag was high
    p_fault_needs_flag_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $past(sync2));
    // R4: a low synchronised flag clears the qualified fault
    p_flag_low_clears_r4: assert property (@(posedge clk) disable iff (rst)
        !sync2 |=> !fault);
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
    import chop_pkg::*;
#(
    parameter int ON_CYC  = 2000,
    parameter int OFF_CYC = 125000
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic fault,
    output logic gate_en,
    output logic chopping
);
    localparam int MAXC = (OFF_CYC > ON_CYC) ? OFF_CYC : ON_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    chan_state_t   state, state_n;
    logic [TW-1:0] tmr, tmr_n;
    logic          off_last, on_last;

    assign off_last = (tmr == TW'(OFF_CYC - 1));
    assign on_last  = (tmr == TW'(ON_CYC - 1));

    always_comb begin
        state_n = state;
        tmr_n   = tmr;
        unique case (state)
            CH_IDLE: begin
                state_n = CH_CONDUCT;
                tmr_n   = '0;
            end
            CH_CONDUCT: begin
                if (fault) begin
                    state_n = CH_OFFWAIT;
                    tmr_n   = '0;
                end
            end
            CH_OFFWAIT: begin
                if (off_last) begin
                    state_n = CH_ONWIN;
                    tmr_n   = '0;
                end else begin
                    tmr_n = tmr + 1'b1;
                end
            end
            CH_ONWIN: begin
                if (on_last) begin
                    state_n = fault ? CH_OFFWAIT : CH_CONDUCT;
                    tmr_n   = '0;
                end else begin
                    tmr_n = tmr + 1'b1;
                end
            end
        endcase
        if (!req) begin
            state_n = CH_IDLE;
            tmr_n   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CH_IDLE;
            tmr   <= '0;
        end else begin
            state <= state_n;
            tmr   <= tmr_n;
        end
    end

    always_comb begin
        gate_en  = 1'b0;
        chopping = 1'b0;
        unique case (state)
            CH_IDLE:    begin gate_en = 1'b0; chopping = 1'b0; end
            CH_CONDUCT: begin gate_en = 1'b1; chopping = 1'b0; end
            CH_OFFWAIT: begin gate_en = 1'b0; chopping = 1'b1; end
            CH_ONWIN:   begin gate_en = 1'b1; chopping = 1'b1; end
        endcase
    end

    p_unreq_off_r2: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!gate_en && !chopping));
    p_idle_starts_r3: assert property (@(posedge clk) disable iff (rst)
        (req && state == CH_IDLE) |=> (gate_en && !chopping));
    p_fault_cuts_r5: assert property (@(posedge clk) disable iff (rst)
        (req && state == CH_CONDUCT && fault) |=> (!gate_en && chopping));
    p_off_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (req && state == CH_OFFWAIT && !off_last) |=> (state == CH_OFFWAIT));
    p_win_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (req && state == CH_ONWIN && !on_last) |=> (state == CH_ONWIN));
    p_retry_r7: assert property (@(posedge clk) disable iff (rst)
        (req && state == CH_ONWIN && on_last && fault) |=> (!gate_en && chopping));
    p_recover_r8: assert property (@(posedge clk) disable iff (rst)
        (req && state == CH_ONWIN && on_last && !fault) |=> (gate_en && !chopping));
endmodule

// File: rtl/chop_guard.sv
module chop_guard #(
    parameter int NCH     = 8,
    parameter int ON_CYC  = 2000,
    parameter int OFF_CYC = 125000,
    parameter int QUAL    = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] oc_raw,
    output logic [NCH-1:0] gate_en,
    output logic [NCH-1:0] chopping
);
    logic [NCH-1:0] fault;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        oc_qual #(.QUAL(QUAL)) u_qual (
            .clk    (clk),
            .rst    (rst),
            .oc_raw (oc_raw[ch]),
            .fault  (fault[ch])
        );
        chop_fsm #(.ON_CYC(ON_CYC), .OFF_CYC(OFF_CYC)) u_fsm (
            .clk      (clk),
            .rst      (rst),
            .req      (req[ch]),
            .fault    (fault[ch]),
            .gate_en  (gate_en[ch]),
            .chopping (chopping[ch])
        );
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (gate_en == '0 && chopping == '0));
endmodule

// File: tb/chop_guard_bench.sv
module chop_guard_bench;
    localparam int NCH = 8, ONC = 5, OFFC = 12, QL = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic [NCH-1:0] req = '0, oc = '0, gate_en, chopping;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    chop_guard #(.NCH(NCH), .ON_CYC(ONC), .OFF_CYC(OFFC), .QUAL(QL)) u_chop_guard (
        .clk(clk), .rst(rst), .req(req), .oc_raw(oc),
        .gate_en(gate_en), .chopping(chopping));

    task automatic chk(input string r, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b at %0t", r, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
        end
    endtask

    // arithmetic per-channel model: 0 idle, 1 conduct, 2 off, 3 window
    bit m_s1[NCH], m_s2[NCH];
    int m_run[NCH], m_mode[NCH], m_tmr[NCH];

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                m_s1[c] = 0; m_s2[c] = 0; m_run[c] = 0; m_mode[c] = 0; m_tmr[c] = 0;
            end else begin
                bit flt;
                flt = (m_run[c] >= QL);
                if (!req[c]) begin m_mode[c] = 0; m_tmr[c] = 0; end
                else if (m_mode[c] == 0) m_mode[c] = 1;
                else if (m_mode[c] == 1) begin if (flt) begin m_mode[c] = 2; m_tmr[c] = 0; end end
                else if (m_tmr[c] + 1 >= ((m_mode[c] == 2) ? OFFC : ONC)) begin
                    m_mode[c] = (m_mode[c] == 2) ? 3 : (flt ? 2 : 1);
                    m_tmr[c] = 0;
                end else m_tmr[c]++;
                m_run[c] = m_s2[c] ? ((m_run[c] < QL) ? m_run[c] + 1 : QL) : 0;
                m_s2[c] = m_s1[c];
                m_s1[c] = oc[c];
            end
        end
    end

    // R10: every channel tracked every cycle against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [NCH-1:0] eg, ec;
            for (int c = 0; c < NCH; c++) begin
                eg[c] = (m_mode[c] == 1) || (m_mode[c] == 3);
                ec[c] = (m_mode[c] >= 2);
            end
            chk("R10 model gate", gate_en, eg);
            chk("R10 model chop", chopping, ec);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int cnt;
        cyc(3);
        chk("R1 reset gate", gate_en, '0);
        chk("R1 reset chop", chopping, '0);
        rst = 1'b0;
        cyc(2);
        chk("R2 unrequested gate", gate_en, '0);
        req = '1;
        cyc(1);
        chk("R3 conduct on request", gate_en, '1);
        chk("R3 no chop on request", chopping, '0);
        cyc(4);

        // R4 sweep: sub-threshold pulses ignored, threshold pulse trips
        for (int ch = 0; ch < NCH; ch++) begin
            for (int len = 1; len < QL; len++) begin
                oc[ch] = 1'b1; cyc(len); oc[ch] = 1'b0; cyc(QL + 4);
                chk("R4 short pulse ignored", chopping, '0);
                chk("R4 short pulse gate", gate_en, '1);
            end
            oc[ch] = 1'b1; cyc(QL); oc[ch] = 1'b0; cyc(4);
            chk("R4 threshold pulse trips", chopping, NCH'(1) << ch);
            chk("R10 others untouched", gate_en, ~(NCH'(1) << ch));
            req[ch] = 1'b0; cyc(1);
            chk("R9 drop in off interval", chopping, '0);
            req[ch] = 1'b1; cyc(1);
            chk("R9 restart conducts", gate_en, '1);
            cyc(2);
        end

        // R5/R6/R7: persistent fault on channel 2
        oc[2] = 1'b1;
        cnt = 0;
        while (!chopping[2] && cnt < 50) begin cyc(1); cnt++; end
        chk_int("R4 trip latency", cnt, QL + 3);
        for (int rep = 0; rep < 2; rep++) begin
            cnt = 0;
            do begin cnt++; cyc(1); end while (!gate_en[2] && cnt < 100);
            chk_int("R5 off interval length", cnt, OFFC);
            cnt = 0;
            do begin cnt++; cyc(1); end while (gate_en[2] && cnt < 100);
            chk_int("R6 on window length", cnt, ONC);
            chk("R7 back to off interval", {gate_en[2], chopping[2]}, 2'b01);
        end

        // R8: fault clears during off interval
        cyc(3); oc[2] = 1'b0;
        cnt = 0;
        while (!gate_en[2] && cnt < 100) begin cyc(1); cnt++; end
        cyc(ONC + 1);
        chk("R8 continuous after recovery", {gate_en[2], chopping[2]}, 2'b10);
        oc[2] = 1'b1; cyc(QL + 4);
        chk("R8 rising load re-enters chopping", {gate_en[2], chopping[2]}, 2'b01);
        oc[2] = 1'b0;

        // R9: request drop inside on window of channel 5
        oc[5] = 1'b1;
        cnt = 0;
        while (!(gate_en[5] && chopping[5]) && cnt < 100) begin cyc(1); cnt++; end
        cyc(2);
        req[5] = 1'b0; oc[5] = 1'b0; cyc(1);
        chk("R9 drop in on window", {gate_en[5], chopping[5]}, 2'b00);
        cyc(QL + 3);
        req[5] = 1'b1; cyc(1);
        chk("R9 fresh conduction", {gate_en[5], chopping[5]}, 2'b10);

        // R2: requests low, comparators high
        req = '0; oc = '1; cyc(1);
        chk("R2 off when unrequested", gate_en, '0);
        cyc(OFFC + ONC + 5);
        chk("R2 never chopping", chopping, '0);
        chk("R2 gate stays off", gate_en, '0);

        // R1: reset in the middle of chopping
        req = '1; cyc(OFFC + 3);
        chk("R1 precondition chopping", chopping, '1);
        rst = 1'b1; cyc(1);
        chk("R1 reset clears gate", gate_en, '0);
        chk("R1 reset clears chop", chopping, '0);
        rst = 1'b0; oc = '0; req = '0;
        cyc(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule